// File: doc/BRIEF.md
# DMA Descriptor Fetch and Chain Unit

This unit sits between one DMA channel's current-descriptor register and a transfer engine. When started with a descriptor address, it reads the descriptor from memory one word at a time over a request/response read port. It always reads the control word first. It then takes the descriptor kind from that word and reads only the words that kind of descriptor carries. The decoded fields are held on a set of outputs, and `fetched_valid_o` marks them as good.

The transfer engine pulses `done_i` when it has finished with the descriptor. The unit then takes the next-descriptor pointer from the held fields. A zero pointer ends the chain. A pointer that is not 32-byte aligned raises an error. Any other pointer becomes the current descriptor and is fetched in the same way. Data movement, arbitration and triggers are handled elsewhere.

Top module: `dma_desc_fetch`

## Requirements
- R1: After reset, no read is requested, `fetched_valid_o`, `err_o` and `chain_done_o` are low and `cur_ptr_o` is zero.
- R2: `start_i` with a non-zero aligned pointer makes that pointer current and requests the word at that address first. Only one read is outstanding at a time, and a request holds its address until `rd_req_ready_i` accepts it.
- R3: The descriptor kind is control-word bits [30:28]: 0 single, 1 one-dimensional, 2 two-dimensional, 3 memory copy, 4 scatter. Codes 5 to 7 raise `err_o` after the control word, and no further word is read.
- R4: Words are read at consecutive word addresses from the current pointer. The count per kind is: single 4, scatter 4, memory copy 5, one-dimensional 6, two-dimensional 8.
- R5: Word offsets, counted in 32-bit words from the control word at 0:
  - Source is at 1 for every kind.
  - Destination is at 2 for every kind except scatter, which has none.
  - X count is at 2 for scatter and at 3 for memory copy, one-dimensional and two-dimensional.
  - X increments are at 4 for one-dimensional and two-dimensional.
  - Y count is at 5 and Y increments at 6, for two-dimensional only.
  - The next pointer is the last word of the descriptor.
- R6: `xcount_o` and `ycount_o` equal the low 16 bits of the stored word plus one, so they range from 1 to 65536. A field that the descriptor kind lacks reads as zero.
- R7: `fetched_valid_o` rises only after the last needed word has returned. It then stays high, with no request, until `done_i`.
- R8: `done_i` with a non-zero aligned next pointer loads that pointer into `cur_ptr_o` and starts a new fetch from it.
- R9: `done_i` with a zero next pointer clears `cur_ptr_o`, pulses `chain_done_o` for exactly one cycle and returns the unit to idle.
- R10: A start or next pointer whose low 5 bits are not zero raises `err_o` without any read, and `cur_ptr_o` is left unchanged. A later `start_i` clears the error.
- R11: `start_i` and `done_i` have no effect while a fetch is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a chain at start_ptr_i (idle or error state) |
| start_ptr_i | input | 32 | First descriptor byte address |
| done_i | input | 1 | Transfer engine finished with the current descriptor |
| rd_req_valid_o | output | 1 | Word read request valid |
| rd_req_addr_o | output | 32 | Word read byte address |
| rd_req_ready_i | input | 1 | Memory accepts the request |
| rd_rsp_valid_i | input | 1 | Read data returned |
| rd_rsp_data_i | input | 32 | Read data |
| fetched_valid_o | output | 1 | Decoded fields are complete |
| desc_type_o | output | 3 | Descriptor kind code |
| ctl_o | output | 32 | Control word |
| src_o | output | 32 | Source address |
| dst_o | output | 32 | Destination address, zero if absent |
| xcount_o | output | 17 | X element count, zero if absent |
| xincr_o | output | 32 | X increments word, zero if absent |
| ycount_o | output | 17 | Y element count, zero if absent |
| yincr_o | output | 32 | Y increments word, zero if absent |
| next_o | output | 32 | Next descriptor pointer |
| cur_ptr_o | output | 32 | Current descriptor pointer |
| chain_done_o | output | 1 | One-cycle pulse when a chain ends |
| err_o | output | 1 | Bad descriptor kind or misaligned pointer |

## Verification
The hardest case to reach from the ports is a chain that switches descriptor kind from one link to the next. A misaligned pointer that turns up only as a next pointer, after a good fetch, is equally hard. The stimulus builds linked chains of random kinds in a bench memory and varies the handshake delays at random. It also places a deliberately misaligned next pointer behind a valid descriptor. Every read address is logged and compared with the word sequence each kind should produce.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned TYPE_LSB = 28;
  localparam int unsigned N_ROLE   = 8;

  typedef enum logic [2:0] {
    DT_SINGLE  = 3'd0,
    DT_1D      = 3'd1,
    DT_2D      = 3'd2,
    DT_MEMCPY  = 3'd3,
    DT_SCATTER = 3'd4
  } dtype_e;

  typedef enum logic [2:0] {
    RL_CTL  = 3'd0,
    RL_SRC  = 3'd1,
    RL_DST  = 3'd2,
    RL_XCNT = 3'd3,
    RL_XINC = 3'd4,
    RL_YCNT = 3'd5,
    RL_YINC = 3'd6,
    RL_NEXT = 3'd7
  } role_e;

  function automatic logic code_ok(logic [2:0] c);
    return c <= 3'd4;
  endfunction
endpackage

// File: rtl/dma_desc_layout.sv
module dma_desc_layout
  import dma_desc_pkg::*;
(
  input  logic [2:0] code_i,
  input  logic [2:0] idx_i,
  output logic [2:0] last_o,
  output role_e      role_o
);
  // word index -> field role, per descriptor kind
  always_comb begin
    last_o = 3'd0;
    role_o = RL_CTL;
    case (code_i)
      DT_SINGLE: begin
        last_o = 3'd3;
        case (idx_i)
          3'd1:    role_o = RL_SRC;
          3'd2:    role_o = RL_DST;
          3'd3:    role_o = RL_NEXT;
          default: role_o = RL_CTL;
        endcase
      end
      DT_SCATTER: begin
        last_o = 3'd3;
        case (idx_i)
          3'd1:    role_o = RL_SRC;
          3'd2:    role_o = RL_XCNT;
          3'd3:    role_o = RL_NEXT;
          default: role_o = RL_CTL;
        endcase
      end
      DT_MEMCPY: begin
        last_o = 3'd4;
        case (idx_i)
          3'd1:    role_o = RL_SRC;
          3'd2:    role_o = RL_DST;
          3'd3:    role_o = RL_XCNT;
          3'd4:    role_o = RL_NEXT;
          default: role_o = RL_CTL;
        endcase
      end
      DT_1D: begin
        last_o = 3'd5;
        case (idx_i)
          3'd1:    role_o = RL_SRC;
          3'd2:    role_o = RL_DST;
          3'd3:    role_o = RL_XCNT;
          3'd4:    role_o = RL_XINC;
          3'd5:    role_o = RL_NEXT;
          default: role_o = RL_CTL;
        endcase
      end
      DT_2D: begin
        last_o = 3'd7;
        case (idx_i)
          3'd1:    role_o = RL_SRC;
          3'd2:    role_o = RL_DST;
          3'd3:    role_o = RL_XCNT;
          3'd4:    role_o = RL_XINC;
          3'd5:    role_o = RL_YCNT;
          3'd6:    role_o = RL_YINC;
          3'd7:    role_o = RL_NEXT;
          default: role_o = RL_CTL;
        endcase
      end
      default: begin
        last_o = 3'd0;
        role_o = RL_CTL;
      end
    endcase
  end
endmodule

// File: rtl/dma_desc_fields.sv
module dma_desc_fields
  import dma_desc_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     wr_i,
  input  role_e                    role_i,
  input  logic [DW-1:0]            data_i,
  output logic [N_ROLE-1:0][DW-1:0] words_o,
  output logic [N_ROLE-1:0]        seen_o
);
  for (genvar g = 0; g < N_ROLE; g++) begin : g_role
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        words_o[g] <= '0;
        seen_o[g]  <= 1'b0;
      end else if (clr_i) begin
        words_o[g] <= '0;
        seen_o[g]  <= 1'b0;
      end else if (wr_i && (role_i == role_e'(g))) begin
        words_o[g] <= data_i;
        seen_o[g]  <= 1'b1;
      end
    end
  end

  // clear only happens on a load, never with a response in flight (R5)
  assert_no_clr_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && wr_i));
endmodule

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
  import dma_desc_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned ALIGN_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [WORD_W-1:0]   start_ptr_i,
  input  logic                done_i,
  output logic                rd_req_valid_o,
  output logic [WORD_W-1:0]   rd_req_addr_o,
  input  logic                rd_req_ready_i,
  input  logic                rd_rsp_valid_i,
  input  logic [WORD_W-1:0]   rd_rsp_data_i,
  output logic                fetched_valid_o,
  output logic [2:0]          desc_type_o,
  output logic [WORD_W-1:0]   ctl_o,
  output logic [WORD_W-1:0]   src_o,
  output logic [WORD_W-1:0]   dst_o,
  output logic [CNT_W:0]      xcount_o,
  output logic [WORD_W-1:0]   xincr_o,
  output logic [CNT_W:0]      ycount_o,
  output logic [WORD_W-1:0]   yincr_o,
  output logic [WORD_W-1:0]   next_o,
  output logic [WORD_W-1:0]   cur_ptr_o,
  output logic                chain_done_o,
  output logic                err_o
);
  localparam int unsigned DW = WORD_W;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_RSP, S_VALID, S_ERR} st_e;

  st_e               state_q;
  logic [2:0]        idx_q, last_q, code_q;
  logic [DW-1:0]     cur_q;
  logic              chain_done_q;

  logic              load_go, load_null, load_bad, load_ok;
  logic [DW-1:0]     load_ptr;
  logic [2:0]        code_sel, last_w;
  role_e             role_w;
  logic              wr_w;
  logic [N_ROLE-1:0][DW-1:0] words;
  logic [N_ROLE-1:0]         seen;

  assign load_go   = ((state_q == S_IDLE || state_q == S_ERR) && start_i) ||
                     (state_q == S_VALID && done_i);
  assign load_ptr  = (state_q == S_VALID) ? words[RL_NEXT] : start_ptr_i;
  assign load_null = (load_ptr == '0);
  assign load_bad  = !load_null && (load_ptr[ALIGN_W-1:0] != '0);
  assign load_ok   = load_go && !load_null && !load_bad;

  assign code_sel = (idx_q == 3'd0) ? rd_rsp_data_i[TYPE_LSB +: 3] : code_q;
  assign wr_w     = (state_q == S_RSP) && rd_rsp_valid_i;

  dma_desc_layout u_layout (
    .code_i (code_sel),
    .idx_i  (idx_q),
    .last_o (last_w),
    .role_o (role_w)
  );

  dma_desc_fields #(.DW(DW)) u_fields (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (load_ok),
    .wr_i    (wr_w),
    .role_i  (role_w),
    .data_i  (rd_rsp_data_i),
    .words_o (words),
    .seen_o  (seen)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      idx_q        <= '0;
      last_q       <= '0;
      code_q       <= '0;
      cur_q        <= '0;
      chain_done_q <= 1'b0;
    end else begin
      chain_done_q <= 1'b0;
      if (load_go) begin
        if (load_null) begin
          cur_q        <= '0;
          chain_done_q <= 1'b1;
          state_q      <= S_IDLE;
        end else if (load_bad) begin
          state_q <= S_ERR;
        end else begin
          cur_q   <= load_ptr;
          idx_q   <= '0;
          state_q <= S_REQ;
        end
      end else begin
        case (state_q)
          S_REQ: if (rd_req_ready_i) state_q <= S_RSP;
          S_RSP: if (rd_rsp_valid_i) begin
            if (idx_q == 3'd0) begin
              if (!code_ok(code_sel)) begin
                state_q <= S_ERR;
              end else begin
                code_q  <= code_sel;
                last_q  <= last_w;
                idx_q   <= 3'd1;
                state_q <= S_REQ;
              end
            end else if (idx_q == last_q) begin
              state_q <= S_VALID;
            end else begin
              idx_q   <= idx_q + 3'd1;
              state_q <= S_REQ;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_req_valid_o  = (state_q == S_REQ);
  assign rd_req_addr_o   = cur_q + {{(DW-5){1'b0}}, idx_q, 2'b00};
  assign fetched_valid_o = (state_q == S_VALID);
  assign err_o           = (state_q == S_ERR);
  assign chain_done_o    = chain_done_q;
  assign cur_ptr_o       = cur_q;
  assign desc_type_o     = code_q;
  assign ctl_o           = words[RL_CTL];
  assign src_o           = words[RL_SRC];
  assign dst_o           = words[RL_DST];
  assign xincr_o         = words[RL_XINC];
  assign yincr_o         = words[RL_YINC];
  assign next_o          = words[RL_NEXT];
  assign xcount_o = seen[RL_XCNT] ? (CNT_W+1)'(words[RL_XCNT][CNT_W-1:0]) + (CNT_W+1)'(1) : '0;
  assign ycount_o = seen[RL_YCNT] ? (CNT_W+1)'(words[RL_YCNT][CNT_W-1:0]) + (CNT_W+1)'(1) : '0;

  logic unused_bits;
  assign unused_bits = ^{words[RL_XCNT][DW-1:CNT_W], words[RL_YCNT][DW-1:CNT_W],
                         seen[RL_CTL], seen[RL_SRC], seen[RL_DST], seen[RL_XINC],
                         seen[RL_YINC], seen[RL_NEXT]};

  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_req_addr_o));
  assert_err_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !rd_req_valid_o && !fetched_valid_o);
  assert_single_nocnt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetched_valid_o && desc_type_o == DT_SINGLE |-> xcount_o == '0 && ycount_o == '0);
  assert_valid_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetched_valid_o |-> !rd_req_valid_o);
  assert_chain_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_done_o |=> !chain_done_o);
  assert_chain_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_done_o |-> cur_ptr_o == '0 && !rd_req_valid_o);
  assert_aligned_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_valid_o |-> cur_ptr_o[ALIGN_W-1:0] == '0);
endmodule

// File: tb/dma_desc_fetch_tb_top.sv
`timescale 1ns/1ps
module dma_desc_fetch_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] start_ptr_i = '0;
  logic        done_i = 1'b0;
  logic        rd_req_valid_o;
  logic [31:0] rd_req_addr_o;
  logic        rd_req_ready_i = 1'b0;
  logic        rd_rsp_valid_i = 1'b0;
  logic [31:0] rd_rsp_data_i = '0;
  logic        fetched_valid_o;
  logic [2:0]  desc_type_o;
  logic [31:0] ctl_o, src_o, dst_o, xincr_o, yincr_o, next_o, cur_ptr_o;
  logic [16:0] xcount_o, ycount_o;
  logic        chain_done_o, err_o;

  always #2.5 clk_i = ~clk_i;

  dma_desc_fetch dut_i (
    .clk_i, .rst_ni, .start_i, .start_ptr_i, .done_i,
    .rd_req_valid_o, .rd_req_addr_o, .rd_req_ready_i,
    .rd_rsp_valid_i, .rd_rsp_data_i,
    .fetched_valid_o, .desc_type_o, .ctl_o, .src_o, .dst_o,
    .xcount_o, .xincr_o, .ycount_o, .yincr_o, .next_o,
    .cur_ptr_o, .chain_done_o, .err_o
  );

  logic [31:0] mem [512];
  logic [31:0] log_q [$];
  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int nwords(input int t);
    case (t)
      0: return 4; 4: return 4; 3: return 5; 1: return 6; default: return 8;
    endcase
  endfunction
  function automatic int off_dst(input int t);  return (t == 4) ? -1 : 2; endfunction
  function automatic int off_x(input int t);    return (t == 0) ? -1 : (t == 4) ? 2 : 3; endfunction
  function automatic int off_xi(input int t);   return (t == 1 || t == 2) ? 4 : -1; endfunction
  function automatic int off_y(input int t);    return (t == 2) ? 5 : -1; endfunction
  function automatic int off_yi(input int t);   return (t == 2) ? 6 : -1; endfunction

  task automatic build(input int slot, input int t, input logic [31:0] nxt, input logic [15:0] xs);
    int b = slot * 8;
    for (int k = 0; k < 8; k++) mem[b+k] = $urandom;
    mem[b][30:28] = 3'(t);
    if (off_x(t) >= 0) mem[b+off_x(t)][15:0] = xs;
    mem[b + nwords(t) - 1] = nxt;
  endtask

  task automatic check_fetch(input int slot, input int t);
    int b = slot * 8;
    int n = nwords(t);
    logic [16:0] ex, ey;
    chk(fetched_valid_o === 1'b1, "R7 fetched_valid", 64'(fetched_valid_o), 1);
    chk(log_q.size() == n, "R4 word count", 64'(log_q.size()), 64'(n));
    for (int k = 0; k < n && k < log_q.size(); k++)
      chk(log_q[k] == 32'(slot*32 + 4*k), (k == 0) ? "R2 first address" : "R4 address", 64'(log_q[k]), 64'(slot*32+4*k));
    chk(desc_type_o == 3'(t), "R3 kind", 64'(desc_type_o), 64'(t));
    chk(src_o == mem[b+1], "R5 src", 64'(src_o), 64'(mem[b+1]));
    chk(dst_o == ((off_dst(t) >= 0) ? mem[b+2] : 32'h0), "R5 dst", 64'(dst_o), 0);
    chk(next_o == mem[b+n-1], "R5 next", 64'(next_o), 64'(mem[b+n-1]));
    chk(xincr_o == ((off_xi(t) >= 0) ? mem[b+4] : 32'h0), "R5 xincr", 64'(xincr_o), 0);
    chk(yincr_o == ((off_yi(t) >= 0) ? mem[b+6] : 32'h0), "R5 yincr", 64'(yincr_o), 0);
    ex = (off_x(t) >= 0) ? 17'(mem[b+off_x(t)][15:0]) + 17'd1 : 17'd0;
    ey = (off_y(t) >= 0) ? 17'(mem[b+5][15:0]) + 17'd1 : 17'd0;
    chk(xcount_o == ex, "R6 xcount", 64'(xcount_o), 64'(ex));
    chk(ycount_o == ey, "R6 ycount", 64'(ycount_o), 64'(ey));
  endtask

  task automatic do_start(input logic [31:0] p);
    @(negedge clk_i);
    log_q.delete();
    start_ptr_i = p; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_fetch(output bit ok);
    ok = 0;
    for (int i = 0; i < 400; i++) begin
      if (fetched_valid_o || err_o) begin ok = 1; break; end
      @(negedge clk_i);
    end
  endtask

  // pulse done_i; returns at the negedge after the accepting edge
  task automatic do_done();
    log_q.delete();
    done_i = 1'b1;
    @(negedge clk_i);
    done_i = 1'b0;
  endtask

  // memory responder: one word at a time, random delays
  initial begin
    logic [31:0] a;
    forever begin
      @(negedge clk_i);
      if (rd_req_valid_o) begin
        repeat ($urandom_range(0, 2)) @(negedge clk_i);
        a = rd_req_addr_o;
        log_q.push_back(a);
        rd_req_ready_i = 1'b1;
        @(negedge clk_i);
        rd_req_ready_i = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk_i);
        rd_rsp_data_i  = mem[a[10:2]];
        rd_rsp_valid_i = 1'b1;
        @(negedge clk_i);
        rd_rsp_valid_i = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit ok;
    void'($urandom(32'd7331));
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!rd_req_valid_o && !fetched_valid_o && !err_o && !chain_done_o && cur_ptr_o == 0,
        "R1 reset", {rd_req_valid_o, fetched_valid_o, err_o, chain_done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // every kind, single-link chains (R4 R5 R6 R9)
    for (int t = 0; t < 5; t++) begin
      build(2 + t, t, 32'h0, 16'(t * 1000));
      do_start(32'((2 + t) * 32));
      wait_fetch(ok);
      check_fetch(2 + t, t);
      do_done();
      chk(chain_done_o === 1'b1, "R9 chain_done pulse", 64'(chain_done_o), 1);
      chk(cur_ptr_o == 0, "R9 cur_ptr cleared", 64'(cur_ptr_o), 0);
      @(negedge clk_i);
      chk(chain_done_o === 1'b0, "R9 pulse one cycle", 64'(chain_done_o), 0);
    end

    // count extremes (R6)
    build(9, 1, 32'h0, 16'hFFFF);
    do_start(32'(9 * 32)); wait_fetch(ok);
    chk(xcount_o == 17'h10000, "R6 max count", 64'(xcount_o), 64'h10000);
    do_done();
    build(9, 4, 32'h0, 16'h0000);
    do_start(32'(9 * 32)); wait_fetch(ok);
    chk(xcount_o == 17'd1, "R6 min count", 64'(xcount_o), 1);
    do_done();

    // bad kind codes (R3)
    for (int c = 5; c < 8; c++) begin
      build(12, 0, 32'h0, 16'h0);
      mem[12*8][30:28] = 3'(c);
      do_start(32'(12 * 32)); wait_fetch(ok);
      repeat (4) @(negedge clk_i);
      chk(err_o === 1'b1, "R3 bad kind error", 64'(err_o), 1);
      chk(log_q.size() == 1, "R3 no more reads", 64'(log_q.size()), 1);
    end

    // misaligned start from error state (R10)
    do_start(32'(13 * 32 + 4));
    repeat (4) @(negedge clk_i);
    chk(err_o === 1'b1 && log_q.size() == 0, "R10 misaligned start", 64'(log_q.size()), 0);
    chk(cur_ptr_o == 32'(12 * 32), "R10 cur_ptr kept", 64'(cur_ptr_o), 64'(12*32));

    // misaligned next pointer (R10), then recovery by start
    build(14, 3, 32'(15 * 32 + 8), 16'h5);
    do_start(32'(14 * 32)); wait_fetch(ok);
    chk(err_o === 1'b0, "R10 error cleared by start", 64'(err_o), 0);
    check_fetch(14, 3);
    do_done();
    repeat (4) @(negedge clk_i);
    chk(err_o === 1'b1 && log_q.size() == 0, "R10 misaligned next", 64'(log_q.size()), 0);
    chk(cur_ptr_o == 32'(14 * 32), "R10 cur_ptr kept", 64'(cur_ptr_o), 64'(14*32));

    // start/done during a fetch are ignored (R11)
    build(16, 2, 32'h0, 16'h33);
    build(17, 0, 32'h0, 16'h0);
    do_start(32'(16 * 32));
    @(negedge clk_i);
    start_ptr_i = 32'(17 * 32); start_i = 1'b1; done_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; done_i = 1'b0;
    wait_fetch(ok);
    chk(cur_ptr_o == 32'(16 * 32), "R11 start ignored", 64'(cur_ptr_o), 64'(16*32));
    check_fetch(16, 2);
    do_done();

    // random linked chains of mixed kinds (R8)
    for (int it = 0; it < 30; it++) begin
      int len = $urandom_range(1, 3);
      int s0 = 20 + (it % 10) * 4;
      int ty [3];
      for (int j = 0; j < len; j++) begin
        logic [15:0] xs;
        ty[j] = $urandom_range(0, 4);
        xs = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom);
        build(s0 + j, ty[j], (j == len - 1) ? 32'h0 : 32'((s0 + j + 1) * 32), xs);
      end
      do_start(32'(s0 * 32));
      for (int j = 0; j < len; j++) begin
        wait_fetch(ok);
        if (!ok) chk(0, "R7 fetch timeout", 0, 1);
        check_fetch(s0 + j, ty[j]);
        do_done();
        if (j == len - 1) begin
          chk(chain_done_o === 1'b1 && cur_ptr_o == 0, "R9 chain end", 64'(cur_ptr_o), 0);
        end else begin
          chk(cur_ptr_o == 32'((s0 + j + 1) * 32), "R8 next loaded", 64'(cur_ptr_o), 64'((s0+j+1)*32));
        end
      end
    end

    repeat (4) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule